// File: doc/BRIEF.md
# Multicycle Load/Store Processor Datapath

This block is the datapath half of a small 32-bit multicycle processor core that handles register-to-register arithmetic, word loads, word stores, branch-if-equal and an absolute jump. A single word-addressed memory holds both the program and its data, and a single ALU does every addition and comparison. Intermediate results are kept in holding registers (instruction, memory data, two operand registers and an ALU result register) between clock steps. Each architectural step of an instruction takes exactly one clock.

The block has no sequencer of its own. An external controller drives one set of control inputs per clock, and it reads back the opcode of the latched instruction and the ALU zero flag to choose the next step. A secondary word port lets the environment preload or inspect the shared memory.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the PC and every holding register, so `pc` reads 0 and `opcode` reads 0 in the cycle after reset.
- R2: Fetch step (`ir_write`=1, `mem_read`=1, `addr_sel`=0, `alu_src_a`=0, `alu_src_b`=01, `alu_op`=00, `pc_src`=00, `pc_write`=1): the instruction register loads the word at the PC and the PC becomes PC+4 on the same edge. `opcode` shows instruction bits [31:26].
- R3: Operand registers A and B load every clock from the registers named by instruction bits [25:21] and [20:16]. With `alu_src_a`=0 and `alu_src_b`=11, the ALU result register captures PC + (sign-extended bits [15:0] shifted left by 2), which is the branch target.
- R4: `addr_sel`=0 addresses memory with the PC and `addr_sel`=1 addresses it with the ALU result register. `alu_src_b`=10 adds the sign-extended bits [15:0] to A. `mem_write` stores B at that address, and `mem_read` copies the addressed word into the memory data register.
- R5: `alu_op` 00 adds, 01 subtracts, and 10 follows the function field bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other value adds. With `reg_dst`=1 and `mem_to_reg`=0, `reg_write` writes the ALU result register to register bits [15:11].
- R6: With `reg_dst`=0 and `mem_to_reg`=1, `reg_write` writes the memory data register to register bits [20:16].
- R7: `zero` is 1 exactly when the ALU result is 0. The PC loads when `pc_write`=1, or when `pc_write_cond`=1 and `zero`=1. Otherwise it holds. `pc_src`=01 selects the ALU result register, and 00 or 11 selects the live ALU output.
- R8: `pc_src`=10 selects the jump target {PC[31:28], bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: The external port writes `ext_wdata` at `ext_addr` when `ext_we`=1, taking priority over a datapath store in the same cycle. `ext_rdata` shows the addressed word. Addresses that are misaligned or beyond the memory read as 0 and are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_write | input | 1 | Unconditional PC load |
| pc_write_cond | input | 1 | PC load when the ALU result is zero |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_read | input | 1 | Load memory data register from memory |
| mem_write | input | 1 | Store B to memory |
| ir_write | input | 1 | Load instruction register from memory |
| reg_dst | input | 1 | Write register field: 0 bits [20:16], 1 bits [15:11] |
| mem_to_reg | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | ALU A input: 0 PC, 1 register A |
| alu_src_b | input | 2 | ALU B input: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | input | 2 | 00 add, 01 subtract, 10 from function field |
| pc_src | input | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| ext_we | input | 1 | External memory write |
| ext_addr | input | 32 | External byte address |
| ext_wdata | input | 32 | External write data |
| ext_rdata | output | 32 | External read data |
| opcode | output | 6 | Bits [31:26] of the instruction register |
| zero | output | 1 | ALU result equals zero |
| pc | output | 32 | Current program counter |

## Verification
The bench goes after a not-taken branch, where a PC that loaded without checking `zero` would fall to the branch target. It also runs a taken branch with a negative offset, which exposes a missing sign extension or a missing shift of the immediate. A write to register 0 is followed by a store of register 0 over a nonzero word, so a register file that keeps the write would leave a nonzero value in memory. Signed set-less-than, subtraction into a negative value, a jump, and out-of-range or misaligned port accesses each catch a wrong operation select, a wrong target concatenation or a memory wrap-around.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FIELD = 2'b10
    } aluop_e;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'b00,
        SRCB_FOUR = 2'b01,
        SRCB_IMM  = 2'b10,
        SRCB_IMM4 = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_ALU  = 2'b00,
        PCS_HELD = 2'b01,
        PCS_JUMP = 2'b10
    } pcsrc_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_SLT
    } alufn_e;

    localparam logic [5:0] FIELD_ADD = 6'h20;
    localparam logic [5:0] FIELD_SUB = 6'h22;
    localparam logic [5:0] FIELD_AND = 6'h24;
    localparam logic [5:0] FIELD_OR  = 6'h25;
    localparam logic [5:0] FIELD_SLT = 6'h2A;

    typedef struct packed {
        logic   pc_write;
        logic   pc_write_cond;
        logic   addr_sel;
        logic   mem_read;
        logic   mem_write;
        logic   ir_write;
        logic   reg_dst;
        logic   mem_to_reg;
        logic   reg_write;
        logic   src_a;
        srcb_e  src_b;
        aluop_e alu_op;
        pcsrc_e pc_src;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alufn_e pick_fn(input aluop_e op, input logic [5:0] field);
        alufn_e f;
        case (op)
            AOP_ADD: f = FN_ADD;
            AOP_SUB: f = FN_SUB;
            AOP_FIELD: begin
                case (field)
                    FIELD_SUB: f = FN_SUB;
                    FIELD_AND: f = FN_AND;
                    FIELD_OR:  f = FN_OR;
                    FIELD_SLT: f = FN_SLT;
                    default:   f = FN_ADD;
                endcase
            end
            default: f = FN_ADD;
        endcase
        return f;
    endfunction

    function automatic logic [XLEN-1:0] alu_eval(input alufn_e f,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
        logic [XLEN-1:0] y;
        case (f)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  aluop_e          op,
    input  logic [5:0]      field,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    alufn_e fn;

    always_comb begin
        fn   = pick_fn(op, field);
        y    = alu_eval(fn, a, b);
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr1,
    input  logic [AW-1:0]   raddr2,
    output logic [XLEN-1:0] rdata1,
    output logic [XLEN-1:0] rdata2
);
    localparam int NREGS = 1 << AW;

    logic [XLEN-1:0] regs [1:NREGS-1];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) regs[waddr] <= wdata;
    end

    always_comb begin
        rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
        rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];
    end

    // R6: a write to a nonzero register is visible on a read port next cycle
    a_r6_write_visible: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0) && (raddr1 == waddr)) |=>
            (($past(raddr1) != raddr1) || (rdata1 == $past(wdata))));
endmodule

// File: rtl/mc_memory.sv
module mc_memory
    import mc_pkg::*;
#(
    parameter int WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    input  logic            ext_we,
    input  logic [XLEN-1:0] ext_addr,
    input  logic [XLEN-1:0] ext_wdata,
    output logic [XLEN-1:0] ext_rdata
);
    localparam int IW = $clog2(WORDS);
    localparam int HI = IW + 2;

    logic [XLEN-1:0] mem [WORDS];
    logic            hit_p, hit_e;
    logic [IW-1:0]   idx_p, idx_e;

    always_comb begin
        hit_p     = (addr[XLEN-1:HI] == '0) && (addr[1:0] == 2'b00);
        hit_e     = (ext_addr[XLEN-1:HI] == '0) && (ext_addr[1:0] == 2'b00);
        idx_p     = addr[HI-1:2];
        idx_e     = ext_addr[HI-1:2];
        rdata     = hit_p ? mem[idx_p] : '0;
        ext_rdata = hit_e ? mem[idx_e] : '0;
    end

    always_ff @(posedge clk) begin
        if (ext_we && hit_e)  mem[idx_e] <= ext_wdata;
        else if (we && hit_p) mem[idx_p] <= wdata;
    end

    // R4: a datapath store lands at the addressed word
    a_r4_store_lands: assert property (@(posedge clk) disable iff (rst)
        (we && hit_p && !ext_we) |=> (mem[$past(idx_p)] == $past(wdata)));

    // R10: external write takes effect
    a_r10_ext_write: assert property (@(posedge clk) disable iff (rst)
        (ext_we && hit_e) |=> (mem[$past(idx_e)] == $past(ext_wdata)));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_write,
    input  logic        pc_write_cond,
    input  logic        addr_sel,
    input  logic        mem_read,
    input  logic        mem_write,
    input  logic        ir_write,
    input  logic        reg_dst,
    input  logic        mem_to_reg,
    input  logic        reg_write,
    input  logic        alu_src_a,
    input  logic [1:0]  alu_src_b,
    input  logic [1:0]  alu_op,
    input  logic [1:0]  pc_src,
    input  logic        ext_we,
    input  logic [31:0] ext_addr,
    input  logic [31:0] ext_wdata,
    output logic [31:0] ext_rdata,
    output logic [5:0]  opcode,
    output logic        zero,
    output logic [31:0] pc
);
    ctrl_t c;

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [XLEN-1:0] mem_addr, mem_rdata, rf_rd1, rf_rd2;
    logic [XLEN-1:0] alu_in_a, alu_in_b, alu_y, imm_ext, jump_tgt, pc_next, rf_wdata;
    logic [4:0]      rf_waddr;
    logic            alu_zero, pc_en;

    always_comb begin
        c.pc_write      = pc_write;
        c.pc_write_cond = pc_write_cond;
        c.addr_sel      = addr_sel;
        c.mem_read      = mem_read;
        c.mem_write     = mem_write;
        c.ir_write      = ir_write;
        c.reg_dst       = reg_dst;
        c.mem_to_reg    = mem_to_reg;
        c.reg_write     = reg_write;
        c.src_a         = alu_src_a;
        c.src_b         = srcb_e'(alu_src_b);
        c.alu_op        = aluop_e'(alu_op);
        c.pc_src        = pcsrc_e'(pc_src);
    end

    always_comb begin
        mem_addr = c.addr_sel ? aluout_q : pc_q;
        imm_ext  = sext16(ir_q[15:0]);
        jump_tgt = {pc_q[31:28], ir_q[25:0], 2'b00};
        alu_in_a = c.src_a ? a_q : pc_q;
        case (c.src_b)
            SRCB_REG:  alu_in_b = b_q;
            SRCB_FOUR: alu_in_b = 32'd4;
            SRCB_IMM:  alu_in_b = imm_ext;
            default:   alu_in_b = {imm_ext[XLEN-3:0], 2'b00};
        endcase
        case (c.pc_src)
            PCS_HELD: pc_next = aluout_q;
            PCS_JUMP: pc_next = jump_tgt;
            default:  pc_next = alu_y;
        endcase
        pc_en    = c.pc_write | (c.pc_write_cond & alu_zero);
        rf_waddr = c.reg_dst ? ir_q[15:11] : ir_q[20:16];
        rf_wdata = c.mem_to_reg ? mdr_q : aluout_q;
    end

    mc_memory #(.WORDS(MEM_WORDS)) u_mem (
        .clk(clk), .rst(rst), .we(c.mem_write), .addr(mem_addr), .wdata(b_q),
        .rdata(mem_rdata), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    mc_regfile #(.AW(5)) u_rf (
        .clk(clk), .rst(rst), .we(c.reg_write), .waddr(rf_waddr), .wdata(rf_wdata),
        .raddr1(ir_q[25:21]), .raddr2(ir_q[20:16]), .rdata1(rf_rd1), .rdata2(rf_rd2)
    );

    mc_alu u_alu (
        .a(alu_in_a), .b(alu_in_b), .op(c.alu_op), .field(ir_q[5:0]),
        .y(alu_y), .zero(alu_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_en)      pc_q  <= pc_next;
            if (c.ir_write) ir_q  <= mem_rdata;
            if (c.mem_read) mdr_q <= mem_rdata;
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_y;
        end
    end

    assign opcode = ir_q[31:26];
    assign zero   = alu_zero;
    assign pc     = pc_q;

    // R1: reset clears the PC
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc_q == '0));

    // R2: fetch step advances the PC by four
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (pc_write && pc_src == 2'b00 && !alu_src_a && alu_src_b == 2'b01 && alu_op == 2'b00)
            |=> (pc_q == $past(pc_q) + 32'd4));

    // R7: no write enable, no PC change
    a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_write && !pc_write_cond) |=> $stable(pc_q));

    // R7: conditional write with nonzero result leaves the PC alone
    a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!pc_write && pc_write_cond && !zero) |=> $stable(pc_q));

    // R7: taken branch loads the held target
    a_r7_taken: assert property (@(posedge clk) disable iff (rst)
        (!pc_write && pc_write_cond && zero && pc_src == 2'b01) |=> (pc_q == $past(aluout_q)));

    // R9: operand A read from register 0 is zero
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (ir_q[25:21] == 5'd0) |=> (a_q == '0));
endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_write, pc_write_cond, addr_sel, mem_read, mem_write, ir_write;
    logic        reg_dst, mem_to_reg, reg_write, alu_src_a;
    logic [1:0]  alu_src_b, alu_op, pc_src;
    logic        ext_we;
    logic [31:0] ext_addr, ext_wdata, ext_rdata, pc;
    logic [5:0]  opcode;
    logic        zero;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4ns clk = ~clk;

    mc_datapath u_mc_datapath (
        .clk(clk), .rst(rst), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
        .addr_sel(addr_sel), .mem_read(mem_read), .mem_write(mem_write),
        .ir_write(ir_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .reg_write(reg_write), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .alu_op(alu_op), .pc_src(pc_src), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .opcode(opcode),
        .zero(zero), .pc(pc)
    );

    typedef struct packed {
        logic [31:0] pc_at;
        logic [31:0] word;
        logic [31:0] pc_after;
        logic        chk;
        logic [31:0] caddr;
        logic [31:0] cval;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t [0:NV-1] VEC = '{
        '{32'h00, 32'h8C010080, 32'h04, 1'b0, 32'h0,  32'h0},        // lw r1
        '{32'h04, 32'h8C020084, 32'h08, 1'b0, 32'h0,  32'h0},        // lw r2
        '{32'h08, 32'h00221820, 32'h0C, 1'b0, 32'h0,  32'h0},        // add r3
        '{32'h0C, 32'hAC030088, 32'h10, 1'b1, 32'h88, 32'h0000000C}, // sw r3
        '{32'h10, 32'h00412022, 32'h14, 1'b0, 32'h0,  32'h0},        // sub r4
        '{32'h14, 32'hAC04008C, 32'h18, 1'b1, 32'h8C, 32'hFFFFFFFE}, // sw r4
        '{32'h18, 32'h10220005, 32'h1C, 1'b0, 32'h0,  32'h0},        // beq not taken
        '{32'h1C, 32'h10210002, 32'h28, 1'b0, 32'h0,  32'h0},        // beq taken
        '{32'h28, 32'h08000010, 32'h40, 1'b0, 32'h0,  32'h0},        // j
        '{32'h40, 32'h00210020, 32'h44, 1'b0, 32'h0,  32'h0},        // add r0
        '{32'h44, 32'hAC000090, 32'h48, 1'b1, 32'h90, 32'h0},        // sw r0
        '{32'h48, 32'h0041282A, 32'h4C, 1'b0, 32'h0,  32'h0},        // slt r5
        '{32'h4C, 32'hAC050094, 32'h50, 1'b1, 32'h94, 32'h1},        // sw r5
        '{32'h50, 32'h00243025, 32'h54, 1'b0, 32'h0,  32'h0},        // or r6
        '{32'h54, 32'hAC060098, 32'h58, 1'b1, 32'h98, 32'hFFFFFFFF}, // sw r6
        '{32'h58, 32'h10000001, 32'h60, 1'b0, 32'h0,  32'h0},        // beq r0,r0
        '{32'h60, 32'h00223824, 32'h64, 1'b0, 32'h0,  32'h0},        // and r7
        '{32'h64, 32'hAC07009C, 32'h68, 1'b1, 32'h9C, 32'h5},        // sw r7
        '{32'h68, 32'h1021FFFA, 32'h54, 1'b0, 32'h0,  32'h0}         // beq back
    };

    task automatic idle();
        pc_write = 0; pc_write_cond = 0; addr_sel = 0; mem_read = 0; mem_write = 0;
        ir_write = 0; reg_dst = 0; mem_to_reg = 0; reg_write = 0; alu_src_a = 0;
        alu_src_b = 2'b00; alu_op = 2'b00; pc_src = 2'b00; ext_we = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ext_write(input logic [31:0] a, input logic [31:0] d);
        ext_we = 1; ext_addr = a; ext_wdata = d;
        tick();
        ext_we = 0;
    endtask

    task automatic run_vec(input vec_t v);
        check("R2 pc before fetch", pc, v.pc_at);
        idle(); pc_write = 1; mem_read = 1; ir_write = 1; alu_src_b = 2'b01;
        tick();
        check("R2 opcode after fetch", {26'd0, opcode}, {26'd0, v.word[31:26]});
        check("R2 pc plus four", pc, v.pc_at + 32'd4);
        idle(); alu_src_b = 2'b11;
        tick();
        case (v.word[31:26])
            6'h00: begin
                idle(); alu_src_a = 1; alu_op = 2'b10; tick();
                idle(); reg_dst = 1; reg_write = 1; tick();
            end
            6'h23: begin
                idle(); alu_src_a = 1; alu_src_b = 2'b10; tick();
                idle(); addr_sel = 1; mem_read = 1; tick();
                idle(); mem_to_reg = 1; reg_write = 1; tick();
            end
            6'h2B: begin
                idle(); alu_src_a = 1; alu_src_b = 2'b10; tick();
                idle(); addr_sel = 1; mem_write = 1; tick();
            end
            6'h04: begin
                idle(); alu_src_a = 1; alu_op = 2'b01; pc_src = 2'b01; pc_write_cond = 1;
                #1;
                check("R7 zero flag on compare", {31'd0, zero},
                      {31'd0, (v.pc_after != v.pc_at + 32'd4)});
                tick();
            end
            6'h02: begin
                idle(); pc_src = 2'b10; pc_write = 1; tick();
            end
            default: ;
        endcase
        idle();
        check("R3 R7 R8 next pc", pc, v.pc_after);
        if (v.chk) begin
            ext_addr = v.caddr;
            #1;
            check("R4 R5 R6 R9 stored word", ext_rdata, v.cval);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #800us;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        rst = 1;
        idle();
        ext_addr = 0;
        ext_wdata = 0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) ext_write(VEC[i].pc_at, VEC[i].word);
        ext_write(32'h80, 32'h7);
        ext_write(32'h84, 32'h5);
        ext_write(32'h90, 32'hDEADBEEF);
        check("R1 pc after reset", pc, 32'h0);
        check("R1 opcode after reset", {26'd0, opcode}, 32'h0);
        rst = 0;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10: out-of-range write is dropped and reads zero
        ext_write(32'h1000, 32'h12345678);
        ext_addr = 32'h1000; #1;
        check("R10 out of range reads zero", ext_rdata, 32'h0);
        ext_addr = 32'h81; #1;
        check("R10 misaligned reads zero", ext_rdata, 32'h0);
        ext_addr = 32'h80; #1;
        check("R10 aligned word readable", ext_rdata, 32'h7);
        ext_addr = 32'h0; #1;
        check("R10 low word not aliased", ext_rdata, 32'h8C010080);

        // R7: idle steps leave the PC alone
        tick();
        tick();
        check("R7 pc holds when idle", pc, 32'h54);

        // R1: reset in the middle of a run
        rst = 1;
        tick();
        check("R1 pc after mid-run reset", pc, 32'h0);
        check("R1 opcode after mid-run reset", {26'd0, opcode}, 32'h0);
        rst = 0;
        tick();

        finish_run();
    end
endmodule